// File: doc/BRIEF.md
# Bulk IN Endpoint Transmit Buffer with Packet Commit

This block sits between a byte-wide producer, typically a DMA engine, and the packet engine of a bulk IN endpoint. It holds two packet buffers of 64 bytes each and uses them in ping-pong fashion. One buffer is filled while the other holds a finished packet waiting for the packet engine. The block decides when the buffer being filled becomes a packet that is ready to send. This is called a commit. After a commit, filling moves on to the next buffer.

When the DMA enable is high, a buffer that reaches 64 bytes commits itself, so a transfer that is a whole number of packets needs no software action. A trailing packet shorter than 64 bytes is committed only when software pulses the commit strobe. A commit strobe that would cause an excess transfer is refused and sets a sticky error flag. When the DMA enable is low, every packet is committed by the strobe, and a strobe on an empty buffer produces a zero-length packet.

The packet engine sees the oldest committed packet, with its byte count from 0 to 64. It reads bytes by offset through a combinational read port. It releases the buffer with a one-cycle done pulse.

Top module: `inpkt_txbuf`

## Requirements
- R1: After reset, wr_ready is 1, rd_avail is 0, and commit_err and ovf are both 0.
- R2: With dma_mode high, the accepted write that brings the fill buffer to 64 bytes commits it. rd_avail (or the next slot in order) shows a 64-byte packet from the following cycle, and filling continues in the other buffer.
- R3: A buffer holding 1 to 63 bytes is never committed automatically. A commit strobe commits it with rd_len equal to its byte count.
- R4: With dma_mode low, a buffer that reaches 64 bytes is not committed. wr_ready stays 0 until a commit strobe commits it as a 64-byte packet.
- R5: A commit strobe is refused and sets commit_err in the next cycle in two cases: dma_mode is high and the fill buffer is empty, or no buffer is free. A refused strobe adds no packet.
- R6: With dma_mode low, a commit strobe on an empty free buffer adds a packet with rd_len 0.
- R7: Packets reach the read side in commit order. rd_data at offset rd_addr returns the k-th accepted byte of that packet for rd_addr = k, and rd_len never exceeds 64.
- R8: rd_done while rd_avail is 1 frees the oldest packet and moves to the next. rd_done while rd_avail is 0 has no effect.
- R9: While both buffers hold committed packets, wr_ready is 0. A write offered while wr_ready is 0 is dropped (never stored) and sets the sticky ovf flag in the next cycle.
- R10: A commit strobe in the same cycle as the write that triggers an automatic commit is refused and flagged. Exactly one 64-byte packet results.
- R11: A commit strobe in the same cycle as an accepted write that does not fill the buffer commits the packet including that byte.
- R12: A synchronous reset empties both buffers, clears byte counts, commit_err and ovf, and returns the fill and read pointers to the first buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_mode | input | 1 | Enables automatic commit of full buffers |
| wr_valid | input | 1 | Byte write request |
| wr_data | input | 8 | Byte to store |
| wr_ready | output | 1 | Fill buffer can accept a byte |
| commit | input | 1 | Software commit strobe |
| rd_avail | output | 1 | A committed packet is waiting |
| rd_len | output | 7 | Byte count of the waiting packet (0 to 64) |
| rd_addr | input | 6 | Byte offset into the waiting packet |
| rd_data | output | 8 | Byte at rd_addr in the waiting packet |
| rd_done | input | 1 | Frees the waiting packet |
| commit_err | output | 1 | Sticky flag for a refused commit strobe |
| ovf | output | 1 | Sticky flag for a dropped write |

## Verification
The interesting collision is between the automatic commit and the software strobe in one clock. The bench raises commit on the very cycle that carries the 64th byte with DMA on. It then expects commit_err to be set, a single 64-byte packet, and no zero-length packet behind it. The other collision it drives is a strobe sharing a cycle with a non-final byte, where the packet length must count that byte. Both are judged only at the ports, through rd_avail, rd_len, the read data and the flags.

// File: rtl/inpkt_pkg.sv
package inpkt_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_AUTO = 2'd1,
      SRC_SW   = 2'd2
   } commit_src_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/inpkt_bank.sv
module inpkt_bank #(
   parameter int DATA_W    = 8,
   parameter int PKT_BYTES = 64,
   localparam int ADDR_W   = $clog2(PKT_BYTES)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [PKT_BYTES];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/inpkt_slot_tab.sv
module inpkt_slot_tab #(
   parameter int PKT_BYTES = 64,
   parameter int NBUF      = 2,
   localparam int CNT_W    = $clog2(PKT_BYTES + 1),
   localparam int IDX_W    = inpkt_pkg::idx_bits(NBUF)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        set_en,
   input  logic [IDX_W-1:0]            set_idx,
   input  logic [CNT_W-1:0]            set_len,
   input  logic                        clr_en,
   input  logic [IDX_W-1:0]            clr_idx,
   output logic [NBUF-1:0]             busy,
   output logic [NBUF-1:0][CNT_W-1:0]  lens
);

   for (genvar i = 0; i < NBUF; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            busy[i] <= 1'b0;
            lens[i] <= '0;
         end else if (set_en && (set_idx == IDX_W'(i))) begin
            busy[i] <= 1'b1;
            lens[i] <= set_len;
         end else if (clr_en && (clr_idx == IDX_W'(i))) begin
            busy[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/inpkt_fill_ctl.sv
module inpkt_fill_ctl #(
   parameter int PKT_BYTES = 64,
   parameter int NBUF      = 2,
   localparam int CNT_W    = $clog2(PKT_BYTES + 1),
   localparam int ADDR_W   = $clog2(PKT_BYTES),
   localparam int IDX_W    = inpkt_pkg::idx_bits(NBUF)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dma_mode,
   input  logic              wr_valid,
   input  logic              commit,
   input  logic [NBUF-1:0]   busy,
   output logic              wr_ready,
   output logic              wr_fire,
   output logic [IDX_W-1:0]  fill_idx,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [CNT_W-1:0]  fill_cnt,
   output logic              commit_go,
   output logic [CNT_W-1:0]  commit_len,
   output logic              commit_err,
   output logic              ovf
);
   import inpkt_pkg::*;

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PKT_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBUF - 1);

   logic             fill_busy;
   logic [CNT_W-1:0] cnt_next;
   logic             auto_hit;
   logic             sw_ok;
   logic             sw_bad;
   commit_src_e      src;

   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
      return (i == LAST_IDX) ? '0 : i + IDX_W'(1);
   endfunction

   assign fill_busy = busy[fill_idx];
   assign wr_ready  = !fill_busy && (fill_cnt < FULL_CNT);
   assign wr_fire   = wr_valid && wr_ready;
   assign wr_addr   = fill_cnt[ADDR_W-1:0];
   assign cnt_next  = fill_cnt + CNT_W'(wr_fire);

   // full-buffer commit in DMA mode, and the software strobe that may
   // collide with it in the same cycle
   assign auto_hit = dma_mode && wr_fire && (cnt_next == FULL_CNT);
   assign sw_ok    = commit && !fill_busy && !auto_hit &&
                     ((cnt_next != '0) || !dma_mode);
   assign sw_bad   = commit && !sw_ok;

   always_comb begin
      if (auto_hit)   src = SRC_AUTO;
      else if (sw_ok) src = SRC_SW;
      else            src = SRC_NONE;
   end

   assign commit_go  = (src != SRC_NONE);
   assign commit_len = cnt_next;

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_idx   <= '0;
         fill_cnt   <= '0;
         commit_err <= 1'b0;
         ovf        <= 1'b0;
      end else begin
         if (commit_go) begin
            fill_idx <= step(fill_idx);
            fill_cnt <= '0;
         end else begin
            fill_cnt <= cnt_next;
         end
         if (sw_bad) begin
            commit_err <= 1'b1;
         end
         if (wr_valid && !wr_ready) begin
            ovf <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/inpkt_drain_ctl.sv
module inpkt_drain_ctl #(
   parameter int PKT_BYTES = 64,
   parameter int NBUF      = 2,
   localparam int CNT_W    = $clog2(PKT_BYTES + 1),
   localparam int IDX_W    = inpkt_pkg::idx_bits(NBUF)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NBUF-1:0]            busy,
   input  logic [NBUF-1:0][CNT_W-1:0] lens,
   input  logic                       rd_done,
   output logic [IDX_W-1:0]           rd_idx,
   output logic                       rd_avail,
   output logic [CNT_W-1:0]           rd_len,
   output logic                       rd_fire
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBUF - 1);

   assign rd_avail = busy[rd_idx];
   assign rd_len   = lens[rd_idx];
   assign rd_fire  = rd_done && rd_avail;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_idx <= '0;
      end else if (rd_fire) begin
         rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + IDX_W'(1);
      end
   end

endmodule

// File: rtl/inpkt_txbuf.sv
module inpkt_txbuf #(
   parameter int DATA_W    = 8,
   parameter int PKT_BYTES = 64,
   parameter int NBUF      = 2,
   localparam int CNT_W    = $clog2(PKT_BYTES + 1),
   localparam int ADDR_W   = $clog2(PKT_BYTES),
   localparam int IDX_W    = inpkt_pkg::idx_bits(NBUF)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dma_mode,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              commit,
   output logic              rd_avail,
   output logic [CNT_W-1:0]  rd_len,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rd_done,
   output logic              commit_err,
   output logic              ovf
);

   if (NBUF < 2) begin : g_bad_nbuf
      $error("inpkt_txbuf: NBUF must be at least 2");
   end
   if (PKT_BYTES < 2) begin : g_bad_pkt
      $error("inpkt_txbuf: PKT_BYTES must be at least 2");
   end
   if ((1 << ADDR_W) != PKT_BYTES) begin : g_bad_pow2
      $error("inpkt_txbuf: PKT_BYTES must be a power of two");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("inpkt_txbuf: DATA_W must be positive");
   end

   logic                       wr_fire;
   logic [IDX_W-1:0]           fill_idx;
   logic [ADDR_W-1:0]          wr_addr;
   logic [CNT_W-1:0]           fill_cnt;
   logic                       commit_go;
   logic [CNT_W-1:0]           commit_len;
   logic [NBUF-1:0]            busy;
   logic [NBUF-1:0][CNT_W-1:0] lens;
   logic [IDX_W-1:0]           rd_idx;
   logic                       rd_fire;
   logic [NBUF-1:0][DATA_W-1:0] bank_q;

   inpkt_fill_ctl #(.PKT_BYTES(PKT_BYTES), .NBUF(NBUF)) u_fill (
      .clk        (clk),
      .rst        (rst),
      .dma_mode   (dma_mode),
      .wr_valid   (wr_valid),
      .commit     (commit),
      .busy       (busy),
      .wr_ready   (wr_ready),
      .wr_fire    (wr_fire),
      .fill_idx   (fill_idx),
      .wr_addr    (wr_addr),
      .fill_cnt   (fill_cnt),
      .commit_go  (commit_go),
      .commit_len (commit_len),
      .commit_err (commit_err),
      .ovf        (ovf)
   );

   inpkt_slot_tab #(.PKT_BYTES(PKT_BYTES), .NBUF(NBUF)) u_slots (
      .clk     (clk),
      .rst     (rst),
      .set_en  (commit_go),
      .set_idx (fill_idx),
      .set_len (commit_len),
      .clr_en  (rd_fire),
      .clr_idx (rd_idx),
      .busy    (busy),
      .lens    (lens)
   );

   inpkt_drain_ctl #(.PKT_BYTES(PKT_BYTES), .NBUF(NBUF)) u_drain (
      .clk      (clk),
      .rst      (rst),
      .busy     (busy),
      .lens     (lens),
      .rd_done  (rd_done),
      .rd_idx   (rd_idx),
      .rd_avail (rd_avail),
      .rd_len   (rd_len),
      .rd_fire  (rd_fire)
   );

   for (genvar b = 0; b < NBUF; b++) begin : g_bank
      inpkt_bank #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_bank (
         .clk   (clk),
         .we    (wr_fire && (fill_idx == IDX_W'(b))),
         .waddr (wr_addr),
         .wdata (wr_data),
         .raddr (rd_addr),
         .rdata (bank_q[b])
      );
   end

   assign rd_data = bank_q[rd_idx];

endmodule

// File: rtl/inpkt_txbuf_chk.sv
module inpkt_txbuf_chk #(
   parameter int PKT_BYTES = 64,
   parameter int NBUF      = 2,
   localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
   input logic             clk,
   input logic             rst,
   input logic             dma_mode,
   input logic             wr_valid,
   input logic             wr_ready,
   input logic             commit,
   input logic             rd_avail,
   input logic [CNT_W-1:0] rd_len,
   input logic             rd_done,
   input logic             commit_err,
   input logic             ovf,
   input logic [CNT_W-1:0] fill_cnt,
   input logic [NBUF-1:0]  busy
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PKT_BYTES);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PKT_BYTES - 1);

   // R1 / R12: state seen in the first cycle after reset ends
   a_r12_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (wr_ready && !rd_avail && !commit_err && !ovf));

   // R2: the byte that fills a buffer in DMA mode adds one packet
   a_r2_auto_commit: assert property (@(posedge clk) disable iff (rst)
      (dma_mode && wr_valid && wr_ready && fill_cnt == LAST_CNT && !rd_done)
      |=> ($countones(busy) == $past($countones(busy)) + 1));

   // R3: a non-filling byte without a strobe adds no packet
   a_r3_no_auto_short: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready && fill_cnt < LAST_CNT && !commit && !rd_done)
      |=> ($countones(busy) == $past($countones(busy))));

   // R4: full buffer outside DMA mode blocks writes
   a_r4_hold_full: assert property (@(posedge clk) disable iff (rst)
      (!dma_mode && fill_cnt == FULL_CNT) |-> !wr_ready);

   // R5: strobe on an empty buffer in DMA mode is flagged
   a_r5_spurious: assert property (@(posedge clk) disable iff (rst)
      (commit && dma_mode && fill_cnt == '0 && !(wr_valid && wr_ready))
      |=> commit_err);

   // R7: reported length stays within one buffer
   a_r7_len_range: assert property (@(posedge clk) disable iff (rst)
      rd_avail |-> (rd_len <= FULL_CNT));

   // R8: a taken done pulse frees exactly one packet
   a_r8_free_one: assert property (@(posedge clk) disable iff (rst)
      (rd_done && rd_avail && !commit && !(wr_valid && wr_ready))
      |=> ($countones(busy) == $past($countones(busy)) - 1));

   // R9: refused write sets the overflow flag
   a_r9_overflow: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ready) |=> ovf);

endmodule

bind inpkt_txbuf inpkt_txbuf_chk #(.PKT_BYTES(PKT_BYTES), .NBUF(NBUF)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .dma_mode   (dma_mode),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .commit     (commit),
   .rd_avail   (rd_avail),
   .rd_len     (rd_len),
   .rd_done    (rd_done),
   .commit_err (commit_err),
   .ovf        (ovf),
   .fill_cnt   (fill_cnt),
   .busy       (busy)
);

// File: tb/tb_inpkt_txbuf.sv
`timescale 1ns/1ps
module tb_inpkt_txbuf;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       dma_mode = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_ready;
   logic       commit = 1'b0;
   logic       rd_avail;
   logic [6:0] rd_len;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       rd_done = 1'b0;
   logic       commit_err;
   logic       ovf;

   int checks = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;
   int wcnt = 0;
   int rd_pos = 0;
   int exp_q[$];

   always #2 clk = ~clk;

   inpkt_txbuf dut (
      .clk(clk), .rst(rst), .dma_mode(dma_mode), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_ready(wr_ready), .commit(commit),
      .rd_avail(rd_avail), .rd_len(rd_len), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_done(rd_done), .commit_err(commit_err),
      .ovf(ovf)
   );

   // vector: {dma, byte count, chunk for software commits}
   localparam int NVEC = 10;
   localparam logic [23:0] VEC [NVEC] = '{
      {1'b1, 15'd150, 8'd64}, {1'b1, 15'd128, 8'd64},
      {1'b1, 15'd1,   8'd64}, {1'b1, 15'd63,  8'd64},
      {1'b1, 15'd64,  8'd64}, {1'b1, 15'd200, 8'd64},
      {1'b0, 15'd10,  8'd3 }, {1'b0, 15'd64,  8'd64},
      {1'b0, 15'd130, 8'd64}, {1'b0, 15'd5,   8'd1 }
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      exp_q.delete();
      wcnt = 0;
      rd_pos = 0;
   endtask

   task automatic send_byte(input bit with_commit);
      wr_valid = 1'b1;
      wr_data  = wcnt[7:0];
      commit   = with_commit;
      wcnt++;
      @(negedge clk);
      wr_valid = 1'b0;
      commit   = 1'b0;
   endtask

   task automatic send_raw(input logic [7:0] d);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic strobe();
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
   endtask

   task automatic drain_one(input string tag);
      int len;
      int miss;
      if (exp_q.size() == 0) begin
         chk(1'b0, {tag, " model queue empty"}, 0, 1);
         return;
      end
      len = exp_q.pop_front();
      miss = 0;
      chk(rd_avail == 1'b1, {tag, " R7 rd_avail"}, int'(rd_avail), 1);
      chk(int'(rd_len) == len, {tag, " R7 rd_len"}, int'(rd_len), len);
      for (int k = 0; k < len; k++) begin
         rd_addr = 6'(k);
         #0.01;
         if (rd_data != 8'((rd_pos + k) & 255)) miss++;
      end
      chk(miss == 0, {tag, " R7 data mismatches"}, miss, 0);
      rd_pos += len;
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
   endtask

   task automatic run_vec(input bit dma, input int n, input int chunk);
      int in_buf = 0;
      int sent = 0;
      string tag;
      tag = dma ? "R2/R3 vec" : "R4/R6 vec";
      dma_mode = dma;
      while (sent < n) begin
         if (!wr_ready) begin
            drain_one(tag);
         end else begin
            send_byte(1'b0);
            sent++;
            in_buf++;
            if (dma && in_buf == 64) begin
               exp_q.push_back(64);
               in_buf = 0;
            end else if (!dma && in_buf == chunk) begin
               strobe();
               exp_q.push_back(chunk);
               in_buf = 0;
            end
         end
      end
      if (in_buf > 0) begin
         strobe();
         exp_q.push_back(in_buf);
      end
      while (exp_q.size() > 0) drain_one(tag);
      chk(rd_avail == 1'b0, {tag, " R3 no extra packet"}, int'(rd_avail), 0);
      chk(commit_err == 1'b0, {tag, " R3 no error"}, int'(commit_err), 0);
      chk(ovf == 1'b0, {tag, " R9 no overflow"}, int'(ovf), 0);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         checks++;
         bad++;
         $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
      chk(rd_avail == 1'b0, "R1 rd_avail", int'(rd_avail), 0);
      chk(commit_err == 1'b0 && ovf == 1'b0, "R1 flags", int'({commit_err, ovf}), 0);

      // table of transfers
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         run_vec(VEC[v][23], int'(VEC[v][22:8]), int'(VEC[v][7:0]));
      end

      // R5: strobe on empty buffer in DMA mode
      do_reset();
      dma_mode = 1'b1;
      strobe();
      chk(commit_err == 1'b1, "R5 empty dma commit flagged", int'(commit_err), 1);
      chk(rd_avail == 1'b0, "R5 no packet added", int'(rd_avail), 0);

      // R6: zero-length packet outside DMA mode
      do_reset();
      dma_mode = 1'b0;
      strobe();
      chk(rd_avail == 1'b1 && rd_len == 7'd0, "R6 zero-length packet", int'(rd_len), 0);
      chk(commit_err == 1'b0, "R6 no error", int'(commit_err), 0);
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      chk(rd_avail == 1'b0, "R8 freed after done", int'(rd_avail), 0);

      // R8: stray done does not move the read side
      do_reset();
      dma_mode = 1'b0;
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      send_byte(1'b0);
      strobe();
      exp_q.push_back(1);
      chk(rd_avail == 1'b1, "R8 stray done ignored", int'(rd_avail), 1);
      drain_one("R8");

      // R11: strobe together with a non-final byte
      do_reset();
      dma_mode = 1'b0;
      send_byte(1'b0);
      send_byte(1'b0);
      send_byte(1'b1);
      exp_q.push_back(3);
      chk(int'(rd_len) == 3, "R11 length includes same-cycle byte", int'(rd_len), 3);
      drain_one("R11");

      // R10: strobe on the cycle of the 64th byte in DMA mode
      do_reset();
      dma_mode = 1'b1;
      for (int i = 0; i < 63; i++) send_byte(1'b0);
      send_byte(1'b1);
      exp_q.push_back(64);
      chk(commit_err == 1'b1, "R10 collision flagged", int'(commit_err), 1);
      drain_one("R10");
      chk(rd_avail == 1'b0, "R10 single packet only", int'(rd_avail), 0);
      chk(wr_ready == 1'b1, "R10 fill continues", int'(wr_ready), 1);

      // R4 / R9: full buffer outside DMA mode
      do_reset();
      dma_mode = 1'b0;
      for (int i = 0; i < 64; i++) send_byte(1'b0);
      chk(rd_avail == 1'b0, "R4 no auto commit", int'(rd_avail), 0);
      chk(wr_ready == 1'b0, "R4 wr_ready low when full", int'(wr_ready), 0);
      send_raw(8'hEE);
      chk(ovf == 1'b1, "R9 overflow on full buffer", int'(ovf), 1);
      strobe();
      exp_q.push_back(64);
      drain_one("R4");

      // R9 / R5: both buffers committed
      do_reset();
      dma_mode = 1'b0;
      send_byte(1'b0); send_byte(1'b0); strobe(); exp_q.push_back(2);
      send_byte(1'b0); send_byte(1'b0); strobe(); exp_q.push_back(2);
      chk(wr_ready == 1'b0, "R9 wr_ready low when both busy", int'(wr_ready), 0);
      send_raw(8'hEE);
      chk(ovf == 1'b1, "R9 dropped write flagged", int'(ovf), 1);
      strobe();
      chk(commit_err == 1'b1, "R5 no free buffer flagged", int'(commit_err), 1);
      drain_one("R9");
      drain_one("R9");
      chk(rd_avail == 1'b0, "R5 refused strobe added nothing", int'(rd_avail), 0);

      // R12: reset clears flags and pointers
      do_reset();
      chk(commit_err == 1'b0 && ovf == 1'b0, "R12 flags cleared", int'({commit_err, ovf}), 0);
      chk(wr_ready == 1'b1 && rd_avail == 1'b0, "R12 buffers empty",
          int'({wr_ready, rd_avail}), 2);

      finish_run();
   end

endmodule